// File: doc/BRIEF.md
# Exclusive Reservation Monitor with Shared Word Store

This block sits between a few processor request ports and a small word store that they all share. It gives them the two halves of an atomic read-modify-write. A reserving load reads a word and records that the port has claimed it. A conditional store writes the word only if that claim is still unbroken, and it reports the outcome as a one-bit status. Software builds spin locks on this pair: it reads the lock word with a reserving load, and it tries to take the lock with a conditional store, retrying while the status says the store failed.

Each port keeps one private reservation, which is always set by a reserving load. Each port also keeps one coherent reservation, which is set only when the request carries the shared flag. Any port that commits a write to a word breaks the claims of all other ports on that word. Requests from all ports are accepted in every cycle. Within one cycle the ports are applied in index order, and every response comes back one cycle after its request.

Top module: `excl_mon`

## Requirements
- R1: Every request returns its response exactly one cycle later on the same port. The effective byte address is base plus offset, taken modulo the address space. The word index is that address divided by four. Operation codes are: 0 plain read, 1 plain write, 2 reserving load, 3 conditional store.
- R2: A reserving load returns the addressed word and replaces the port's earlier reservation with one on that word. When the shared flag is set it also records a coherent reservation on the word; when the flag is clear it drops any coherent reservation the port held.
- R3: A conditional store writes its data only if the port's private reservation names the same word and, when the store's shared flag is set, the port's coherent reservation also names that word. The status is 0 when the word was written and 1 when it was not, and a failed store leaves the memory unchanged. Non-conditional operations always report status 0.
- R4: Every conditional store, whether it succeeds or fails, clears both reservations of its own port.
- R5: A successful conditional store or a plain write to a word clears the reservations of every other port on that word. A later conditional store by those ports then fails.
- R6: Requests in the same cycle take effect in ascending port order. When several ports issue conditional stores to the same reserved word in one cycle, only the lowest-indexed port can succeed.
- R7: A request whose base or offset has either of its two low bits non-zero raises the error flag. It returns read data 0, changes neither memory nor any reservation, and a conditional store in this case reports status 1.
- R8: Reset clears every word to 0 and every reservation, and drops all response valids. A conditional store issued before any reserving load fails.
- R9: Reads return the word as it stood before the current cycle's writes. When several ports write one word in the same cycle, the highest-indexed writer's data remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_vld | input | NP | Request valid, one bit per port |
| req_op | input | 2*NP | Operation code per port |
| req_base | input | AW*NP | Base byte address per port |
| req_off | input | OFFW*NP | Byte offset per port (multiple of 4, 0..1020) |
| req_shared | input | NP | Shared attribute of the access per port |
| req_wdata | input | DW*NP | Write data per port |
| rsp_vld | output | NP | Response valid per port |
| rsp_rdata | output | DW*NP | Read data per port |
| rsp_fail | output | NP | Conditional store status: 1 means not written |
| rsp_err | output | NP | Misaligned request flag |

## Verification
The bench builds the monitor with three ports, sixteen words and a ten-bit offset. With three ports it can run a three-way race on one word and check that one writer wins while the other two fail. With sixteen words the six-bit address wraps after 64 bytes, so an offset that crosses the top of the address space is reachable with a small base. Random traffic is confined to four words, so that reservations are broken by other ports often and collisions within one cycle are common.

// File: rtl/excl_mon.sv
`timescale 1ns/1ps
module excl_mon #(
  parameter int NP    = 3,
  parameter int WORDS = 16,
  parameter int DW    = 32,
  parameter int OFFW  = 10,
  localparam int WW   = $clog2(WORDS),
  localparam int AW   = WW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NP-1:0]      req_vld,
  input  logic [2*NP-1:0]    req_op,
  input  logic [AW*NP-1:0]   req_base,
  input  logic [OFFW*NP-1:0] req_off,
  input  logic [NP-1:0]      req_shared,
  input  logic [DW*NP-1:0]   req_wdata,
  output logic [NP-1:0]      rsp_vld,
  output logic [DW*NP-1:0]   rsp_rdata,
  output logic [NP-1:0]      rsp_fail,
  output logic [NP-1:0]      rsp_err
);
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_LDX = 2'd2, OP_STX = 2'd3;

  logic [DW-1:0] mem   [WORDS];
  logic [DW-1:0] mem_n [WORDS];
  logic [NP-1:0] lv, lv_n, gv, gv_n;
  logic [WW-1:0] la [NP];
  logic [WW-1:0] la_n [NP];
  logic [WW-1:0] ga [NP];
  logic [WW-1:0] ga_n [NP];
  logic [DW*NP-1:0] rd_n;
  logic [NP-1:0] fail_n, err_n;

  always_comb begin
    mem_n  = mem;
    lv_n   = lv;
    gv_n   = gv;
    la_n   = la;
    ga_n   = ga;
    rd_n   = '0;
    fail_n = '0;
    err_n  = '0;
    for (int i = 0; i < NP; i++) begin
      logic [1:0]    op;
      logic [AW-1:0] base, ea;
      logic [OFFW-1:0] off;
      logic [WW-1:0] w;
      logic          wr, ok;
      op   = req_op[2*i +: 2];
      base = req_base[AW*i +: AW];
      off  = req_off[OFFW*i +: OFFW];
      ea   = base + AW'(off);
      w    = ea[AW-1:2];
      wr   = 1'b0;
      ok   = 1'b0;
      if (req_vld[i]) begin
        if (base[1:0] != 2'b00 || off[1:0] != 2'b00) begin
          err_n[i]  = 1'b1;
          fail_n[i] = (op == OP_STX);
        end else begin
          case (op)
            OP_RD: rd_n[DW*i +: DW] = mem[w];
            OP_WR: wr = 1'b1;
            OP_LDX: begin
              rd_n[DW*i +: DW] = mem[w];
              lv_n[i] = 1'b1;
              la_n[i] = w;
              gv_n[i] = req_shared[i];
              ga_n[i] = w;
            end
            default: begin
              ok = lv_n[i] && la_n[i] == w &&
                   (!req_shared[i] || (gv_n[i] && ga_n[i] == w));
              wr = ok;
              fail_n[i] = !ok;
              lv_n[i] = 1'b0;
              gv_n[i] = 1'b0;
            end
          endcase
          if (wr) begin
            mem_n[w] = req_wdata[DW*i +: DW];
            for (int j = 0; j < NP; j++) begin
              if (j != i) begin
                if (lv_n[j] && la_n[j] == w) lv_n[j] = 1'b0;
                if (gv_n[j] && ga_n[j] == w) gv_n[j] = 1'b0;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < WORDS; k++) mem[k] <= '0;
      for (int k = 0; k < NP; k++) begin
        la[k] <= '0;
        ga[k] <= '0;
      end
      lv        <= '0;
      gv        <= '0;
      rsp_vld   <= '0;
      rsp_rdata <= '0;
      rsp_fail  <= '0;
      rsp_err   <= '0;
    end else begin
      mem       <= mem_n;
      la        <= la_n;
      ga        <= ga_n;
      lv        <= lv_n;
      gv        <= gv_n;
      rsp_vld   <= req_vld;
      rsp_rdata <= rd_n;
      rsp_fail  <= fail_n;
      rsp_err   <= err_n;
    end
  end
endmodule

// File: rtl/excl_mon_chk.sv
`timescale 1ns/1ps
module excl_mon_chk #(
  parameter int NP   = 3,
  parameter int AW   = 6,
  parameter int OFFW = 10,
  parameter int DW   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NP-1:0]      req_vld,
  input logic [2*NP-1:0]    req_op,
  input logic [AW*NP-1:0]   req_base,
  input logic [OFFW*NP-1:0] req_off,
  input logic [NP-1:0]      req_shared,
  input logic [DW*NP-1:0]   req_wdata,
  input logic [NP-1:0]      rsp_vld,
  input logic [DW*NP-1:0]   rsp_rdata,
  input logic [NP-1:0]      rsp_fail,
  input logic [NP-1:0]      rsp_err
);
  logic [AW-1:0] ea [NP];
  logic [NP-1:0] mis, stx;

  for (genvar i = 0; i < NP; i++) begin : g_port
    assign ea[i]  = req_base[AW*i +: AW] + AW'(req_off[OFFW*i +: OFFW]);
    assign mis[i] = req_base[AW*i] | req_base[AW*i+1] | req_off[OFFW*i] | req_off[OFFW*i+1];
    assign stx[i] = req_vld[i] && req_op[2*i +: 2] == 2'd3 && !mis[i];

    // R1
    rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld[i] == ($past(req_vld[i]) && $past(rst_n)));

    // R7
    misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(req_vld[i]) && $past(mis[i])) |->
      (rsp_err[i] && rsp_rdata[DW*i +: DW] == '0 &&
       rsp_fail[i] == ($past(req_op[2*i +: 2]) == 2'd3)));

    // R3
    plain_no_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(req_vld[i]) && $past(req_op[2*i +: 2]) != 2'd3) |-> !rsp_fail[i]);

    for (genvar j = i + 1; j < NP; j++) begin : g_pair
      // R6
      single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stx[i] && stx[j] && ea[i][AW-1:2] == ea[j][AW-1:2])) |->
        (rsp_fail[i] || rsp_fail[j]));
    end
  end
endmodule

bind excl_mon excl_mon_chk #(.NP(NP), .AW(AW), .OFFW(OFFW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
  .req_base(req_base), .req_off(req_off), .req_shared(req_shared),
  .req_wdata(req_wdata), .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata),
  .rsp_fail(rsp_fail), .rsp_err(rsp_err)
);

// File: tb/excl_mon_tb.sv
`timescale 1ns/1ps
module excl_mon_tb;
  localparam int NP = 3, WORDS = 16, DW = 32, OFFW = 10, AW = 6;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0]      req_vld = '0, req_shared = '0;
  logic [2*NP-1:0]    req_op = '0;
  logic [AW*NP-1:0]   req_base = '0;
  logic [OFFW*NP-1:0] req_off = '0;
  logic [DW*NP-1:0]   req_wdata = '0;
  logic [NP-1:0]      rsp_vld, rsp_fail, rsp_err;
  logic [DW*NP-1:0]   rsp_rdata;

  int total = 0, bad = 0;
  bit done = 0;

  int unsigned mm [WORDS];
  bit lv [NP];
  bit gv [NP];
  int la [NP];
  int ga [NP];

  always #2.5 clk = ~clk;

  excl_mon #(.NP(NP), .WORDS(WORDS), .DW(DW), .OFFW(OFFW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
    .req_base(req_base), .req_off(req_off), .req_shared(req_shared),
    .req_wdata(req_wdata), .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata),
    .rsp_fail(rsp_fail), .rsp_err(rsp_err));

  task automatic put(int p, int op, int base, int off, bit sh, int unsigned wd);
    req_vld[p] = 1'b1;
    req_op[2*p +: 2] = 2'(op);
    req_base[AW*p +: AW] = AW'(base);
    req_off[OFFW*p +: OFFW] = OFFW'(off);
    req_shared[p] = sh;
    req_wdata[DW*p +: DW] = wd;
  endtask

  task automatic step(string tag);
    int unsigned snap [WORDS];
    int unsigned e_rd [NP];
    bit e_f [NP];
    bit e_e [NP];
    snap = mm;
    for (int p = 0; p < NP; p++) begin
      int op, base, off, w;
      bit ok;
      e_rd[p] = 0; e_f[p] = 0; e_e[p] = 0;
      if (req_vld[p]) begin
        op   = int'(req_op[2*p +: 2]);
        base = int'(req_base[AW*p +: AW]);
        off  = int'(req_off[OFFW*p +: OFFW]);
        w    = ((base + off) % 64) / 4;
        if (base % 4 != 0 || off % 4 != 0) begin
          e_e[p] = 1; e_f[p] = (op == 3);
        end else begin
          ok = 0;
          if (op == 0) e_rd[p] = snap[w];
          else if (op == 1) ok = 1;
          else if (op == 2) begin
            e_rd[p] = snap[w];
            lv[p] = 1; la[p] = w; gv[p] = req_shared[p]; ga[p] = w;
          end else begin
            ok = lv[p] && la[p] == w && (!req_shared[p] || (gv[p] && ga[p] == w));
            e_f[p] = !ok;
            lv[p] = 0; gv[p] = 0;
          end
          if (ok) begin
            mm[w] = req_wdata[DW*p +: DW];
            for (int q = 0; q < NP; q++)
              if (q != p) begin
                if (la[q] == w) lv[q] = 0;
                if (ga[q] == w) gv[q] = 0;
              end
          end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      total++;
      if (rsp_vld[p] !== req_vld[p] ||
          (req_vld[p] && (rsp_rdata[DW*p +: DW] !== e_rd[p] ||
                          rsp_fail[p] !== e_f[p] || rsp_err[p] !== e_e[p]))) begin
        bad++;
        $display("FAIL %s port%0d: vld=%b rd=%h fail=%b err=%b expected vld=%b rd=%h fail=%b err=%b",
                 tag, p, rsp_vld[p], rsp_rdata[DW*p +: DW], rsp_fail[p], rsp_err[p],
                 req_vld[p], e_rd[p], e_f[p], e_e[p]);
      end
    end
    req_vld = '0;
    req_shared = '0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < WORDS; k++) mm[k] = 0;
    for (int p = 0; p < NP; p++) begin lv[p] = 0; gv[p] = 0; la[p] = 0; ga[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    total++;
    if (rsp_vld !== '0 || rsp_fail !== '0 || rsp_err !== '0) begin
      bad++;
      $display("FAIL R8 reset outputs: vld=%b fail=%b err=%b expected 0", rsp_vld, rsp_fail, rsp_err);
    end
    // R8: cleared memory and reservations
    put(0, 0, 0, 4, 0, 0); put(1, 3, 8, 0, 0, 32'h11); put(2, 3, 12, 0, 1, 32'h22);
    step("R8");
    // R9: plain write then read
    put(0, 1, 8, 0, 0, 32'hA0A0_0001); step("R9");
    put(1, 0, 4, 4, 0, 0); step("R9");
    // R1: reserving load with offset
    put(1, 2, 4, 4, 0, 0); step("R1");
    // R3: conditional store succeeds, then R4 repeat fails
    put(1, 3, 8, 0, 0, 32'hB0B0_0002); step("R3");
    put(1, 3, 8, 0, 0, 32'hDEAD_0000); step("R4");
    put(2, 0, 8, 0, 0, 0); step("R3");
    // R5: shared reservations broken by another port's store
    put(0, 2, 12, 0, 1, 0); put(2, 2, 0, 12, 1, 0); step("R2");
    put(2, 3, 12, 0, 1, 32'hC0C0_0003); step("R5");
    put(0, 3, 12, 0, 1, 32'hDEAD_0001); step("R5");
    put(1, 0, 12, 0, 0, 0); step("R5");
    // R2: newer reservation replaces older
    put(0, 2, 16, 0, 0, 0); step("R2");
    put(0, 2, 20, 0, 0, 0); step("R2");
    put(0, 3, 16, 0, 0, 32'hDEAD_0002); step("R2");
    // R6: three-way race
    put(0, 2, 24, 0, 1, 0); put(1, 2, 24, 0, 1, 0); put(2, 2, 20, 4, 1, 0); step("R6");
    put(0, 3, 24, 0, 1, 32'h0606_0000); put(1, 3, 24, 0, 1, 32'h0606_0001);
    put(2, 3, 24, 0, 1, 32'h0606_0002); step("R6");
    put(0, 0, 24, 0, 0, 0); step("R6");
    // R5: plain write breaks reservation
    put(1, 2, 28, 0, 1, 0); step("R5");
    put(2, 1, 28, 0, 0, 32'h0707_0707); step("R5");
    put(1, 3, 28, 0, 1, 32'hDEAD_0003); step("R5");
    // R7: misaligned requests change nothing
    put(0, 2, 32, 0, 0, 0); step("R7");
    put(0, 2, 33, 0, 0, 0); put(1, 1, 32, 2, 0, 32'hDEAD_0004); step("R7");
    put(0, 3, 32, 1, 0, 32'hDEAD_0005); step("R7");
    put(0, 3, 32, 0, 0, 32'h0808_0808); step("R7");
    put(1, 0, 32, 0, 0, 0); step("R7");
    // R3: shared store needs coherent reservation
    put(2, 2, 36, 0, 0, 0); step("R3");
    put(2, 3, 36, 0, 1, 32'hDEAD_0006); step("R3");
    // R9: same-cycle read sees old value, last writer remains
    put(0, 1, 40, 0, 0, 32'h1010_0000); put(1, 0, 40, 0, 0, 0);
    put(2, 1, 40, 0, 0, 32'h1010_0002); step("R9");
    put(0, 0, 40, 0, 0, 0); step("R9");
    // R1: address wraps modulo the space
    put(1, 0, 60, 8, 0, 0); step("R1");
    // R5: random traffic on four words
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < NP; p++)
        if ($urandom_range(0, 3) != 0)
          put(p, int'($urandom_range(0, 3)),
              ($urandom_range(0, 15) == 0) ? 1 : 4 * int'($urandom_range(0, 3)),
              ($urandom_range(0, 15) == 0) ? 2 : 0,
              bit'($urandom_range(0, 1)), $urandom());
      step("R5");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule